// File: doc/BRIEF.md
# Predicated Extract-After-Last-Active Unit

This block is a datapath slice for a vector unit whose vector length is fixed by a parameter. Each request carries a vector operand, a predicate with one bit for every byte of the vector, a 64-bit scalar operand and a 2-bit element-size code. The block finds the highest-numbered active element of the vector. It picks the element that follows it, wrapping to element zero when the active element is the final one. It then returns that element zero-extended as a scalar.

When no element is active, the scalar operand is returned instead. It is first cut down to the element width and then zero-extended. Results narrower than 64 bits sit in the low half of the 64-bit result port, and the upper half is cleared.

The unit takes a request on a valid strobe and presents the result one clock later. A two-state controller tracks whether a result is on the output. In ST_IDLE no result is presented. In ST_DONE the result register holds a fresh result and `out_valid` is high. The transitions are as follows:
- CAPTURE goes from ST_IDLE to ST_DONE on a strobe.
- BACK_TO_BACK stays in ST_DONE when another strobe arrives.
- DRAIN goes from ST_DONE to ST_IDLE when there is no strobe.
- Reset forces ST_IDLE.

Top module: `xal_unit`

## Requirements
- R1: The element width in bits is 8 shifted left by `in_size` (0→8, 1→16, 2→32, 3→64). The vector holds VLEN divided by that width elements, and element k occupies bits [k*width +: width].
- R2: An element k is active only when predicate bit k*(width/8) is set, which is the bit of its lowest byte. All other predicate bits have no effect on the result.
- R3: When some element is active and the highest active index L is not the final element, the result is element L+1.
- R4: When the final element is the highest active one, the result is element zero.
- R5: The selected element is zero-extended. For size codes 0 to 2, bits [63:32] of the result are zero.
- R6: When no element is active, the result is the low width bits of `in_scalar`, zero-extended to 64 bits.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_result` changes only in the cycle after a strobe and otherwise holds its value.
- R8: A synchronous active-high reset clears `out_valid` and `out_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are captured on this cycle |
| in_vec | input | VLEN | Vector operand |
| in_pred | input | VLEN/8 | Predicate, one bit per vector byte |
| in_scalar | input | 64 | Scalar operand used when no element is active |
| in_size | input | 2 | Element-size code |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Zero-extended selected element or truncated scalar |

## Verification
The bench builds the unit with VLEN set to 64, so the predicate is only 8 bits wide. At that size every one of the 256 predicate values can be swept under all four size codes. The sweep therefore reaches every pattern of ignored non-base predicate bits, every possible highest active index including the final element and element zero, and the empty predicate, each with random vector and scalar data. Back-to-back strobes and idle cycles between them exercise all three controller transitions.

// File: rtl/xal_pkg.sv
package xal_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } esz_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } xal_state_t;

    function automatic logic [63:0] width_mask(input logic [1:0] code);
        logic [63:0] m;
        unique case (code)
            2'd0: m = 64'h0000_0000_0000_00FF;
            2'd1: m = 64'h0000_0000_0000_FFFF;
            2'd2: m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xal_active_mask.sv
module xal_active_mask #(
    parameter int NB = 32
) (
    input  logic [NB-1:0] pred,
    input  logic [1:0]    size,
    output logic [NB-1:0] act
);
    for (genvar e = 0; e < NB; e++) begin : g_elem
        localparam int I1 = (2 * e < NB) ? 2 * e : 0;
        localparam int I2 = (4 * e < NB) ? 4 * e : 0;
        localparam int I3 = (8 * e < NB) ? 8 * e : 0;
        logic a0, a1, a2, a3;
        assign a0 = pred[e];
        assign a1 = (2 * e < NB) ? pred[I1] : 1'b0;
        assign a2 = (4 * e < NB) ? pred[I2] : 1'b0;
        assign a3 = (8 * e < NB) ? pred[I3] : 1'b0;
        always_comb begin
            unique case (size)
                2'd0: act[e] = a0;
                2'd1: act[e] = a1;
                2'd2: act[e] = a2;
                default: act[e] = a3;
            endcase
        end
    end
endmodule

// File: rtl/xal_last_finder.sv
module xal_last_finder #(
    parameter int NB = 32,
    parameter int IW = 5
) (
    input  logic [NB-1:0] act,
    output logic [IW-1:0] last_idx,
    output logic          any_act
);
    always_comb begin
        last_idx = '0;
        any_act  = 1'b0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (act[i] && !any_act) begin
                last_idx = IW'(i);
                any_act  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xal_elem_select.sv
module xal_elem_select
    import xal_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int NB   = VLEN / 8,
    parameter int IW   = $clog2(NB)
) (
    input  logic [VLEN-1:0] vec,
    input  logic [1:0]      size,
    input  logic [IW-1:0]   last_idx,
    input  logic            any_act,
    input  logic [63:0]     scalar,
    output logic [63:0]     result
);
    localparam int OW = $clog2(VLEN);

    logic [IW:0]     nxt;
    logic [IW:0]     lim;
    logic [OW-1:0]   off;
    logic [VLEN-1:0] shifted;
    logic [63:0]     raw;

    always_comb begin
        lim = (IW + 1)'(NB) >> size;
        nxt = {1'b0, last_idx} + 1'b1;
        if (nxt >= lim) begin
            nxt = '0;
        end
        off     = OW'(nxt) << ({1'b0, size} + 3'd3);
        shifted = vec >> off;
        raw     = any_act ? shifted[63:0] : scalar;
        result  = raw & width_mask(size);
    end
endmodule

// File: rtl/xal_unit.sv
module xal_unit
    import xal_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VLEN-1:0]   in_vec,
    input  logic [VLEN/8-1:0] in_pred,
    input  logic [63:0]       in_scalar,
    input  logic [1:0]        in_size,
    output logic              out_valid,
    output logic [63:0]       out_result
);
    localparam int NB = VLEN / 8;
    localparam int IW = $clog2(NB);

    xal_state_t    state, state_nxt;
    logic [NB-1:0] act;
    logic [IW-1:0] last_idx;
    logic          any_act;
    logic [63:0]   sel_result;
    logic [63:0]   res_q;

    xal_active_mask #(.NB(NB)) u_mask (
        .pred (in_pred),
        .size (in_size),
        .act  (act)
    );

    xal_last_finder #(.NB(NB), .IW(IW)) u_find (
        .act      (act),
        .last_idx (last_idx),
        .any_act  (any_act)
    );

    xal_elem_select #(.VLEN(VLEN), .NB(NB), .IW(IW)) u_sel (
        .vec      (in_vec),
        .size     (in_size),
        .last_idx (last_idx),
        .any_act  (any_act),
        .scalar   (in_scalar),
        .result   (sel_result)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nxt = ST_DONE;   // CAPTURE
            ST_DONE: if (!in_valid) state_nxt = ST_IDLE;  // DRAIN, else BACK_TO_BACK
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (in_valid) begin
            res_q <= sel_result;
        end
    end

    always_comb begin
        out_valid  = (state == ST_DONE);
        out_result = res_q;
    end
endmodule

// File: rtl/xal_unit_chk.sv
module xal_unit_chk #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [VLEN-1:0]   in_vec,
    input logic [VLEN/8-1:0] in_pred,
    input logic [63:0]       in_scalar,
    input logic [1:0]        in_size,
    input logic              out_valid,
    input logic [63:0]       out_result
);
    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                             // R7
    AST_NO_STROBE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                           // R7
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));                                  // R7
    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size != 2'd3) |=> (out_result[63:32] == 32'd0));     // R5
    AST_EMPTY_BYTE_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pred == '0 && in_size == 2'd0)
        |=> (out_result == {56'd0, $past(in_scalar[7:0])}));                 // R6
endmodule

bind xal_unit xal_unit_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/tb_xal_unit.sv
module tb_xal_unit;
    localparam int VLEN = 64;
    localparam int NB = VLEN / 8;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [63:0]   in_vec;
    logic [NB-1:0] in_pred;
    logic [63:0]   in_scalar;
    logic [1:0]    in_size;
    logic          out_valid;
    logic [63:0]   out_result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xal_unit #(.VLEN(VLEN)) dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_vec     (in_vec),
        .in_pred    (in_pred),
        .in_scalar  (in_scalar),
        .in_size    (in_size),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] ref_model(input logic [63:0] v, input logic [NB-1:0] p,
                                              input logic [63:0] s, input logic [1:0] sz,
                                              output string tag);
        int w = 8 << sz;
        int n = VLEN / w;
        int step = w / 8;
        int last = -1;
        int idx;
        logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        for (int e = 0; e < n; e++) begin
            if (p[e * step]) last = e;
        end
        if (last < 0) begin
            tag = "R6/R2";
            return s & m;
        end
        idx = last + 1;
        tag = "R3/R1";
        if (idx == n) begin
            idx = 0;
            tag = "R4";
        end
        return (v >> (idx * w)) & m;
    endfunction

    task automatic run_op(input logic [63:0] v, input logic [NB-1:0] p,
                          input logic [63:0] s, input logic [1:0] sz);
        string tag;
        logic [63:0] exp;
        exp = ref_model(v, p, s, sz, tag);
        in_valid  = 1'b1;
        in_vec    = v;
        in_pred   = p;
        in_scalar = s;
        in_size   = sz;
        @(negedge clk);
        check("R7 valid", {63'd0, out_valid}, 64'd1);
        check(tag, out_result, exp);
        if (sz != 2'd3) check("R5 upper", {32'd0, out_result[63:32]}, 64'd0);
    endtask

    initial begin
        logic [63:0] held;
        rst = 1'b1;
        in_valid = 1'b0;
        in_vec = '0;
        in_pred = '0;
        in_scalar = '0;
        in_size = '0;
        repeat (3) @(negedge clk);
        check("R8 valid", {63'd0, out_valid}, 64'd0);
        check("R8 result", out_result, 64'd0);
        rst = 1'b0;

        // directed corners
        run_op(64'h1122_3344_5566_7788, 8'h00, 64'hAAAA_BBBB_CCCC_DDEE, 2'd0); // R6 empty
        run_op(64'h1122_3344_5566_7788, 8'hFE, 64'h0123_4567_89AB_CDEF, 2'd3); // R2 non-base ignored
        run_op(64'h1122_3344_5566_7788, 8'h80, 64'd0, 2'd0);                   // R4 final only
        run_op(64'h1122_3344_5566_7788, 8'h01, 64'd0, 2'd2);                   // R1 word 1
        run_op(64'h1122_3344_5566_7788, 8'h01, 64'd0, 2'd0);                   // R3 zero only

        // sweep every predicate under every size code
        for (int sz = 0; sz < 4; sz++) begin
            for (int p = 0; p < 256; p++) begin
                run_op({$urandom, $urandom}, NB'(p), {$urandom, $urandom}, 2'(sz));
                if (p % 37 == 0) begin
                    in_valid = 1'b0;
                    held = out_result;
                    in_pred = ~in_pred;
                    in_scalar = ~in_scalar;
                    @(negedge clk);
                    check("R7 drain", {63'd0, out_valid}, 64'd0);
                    check("R7 hold", out_result, held);
                end
            end
        end

        in_valid = 1'b0;
        held = out_result;
        repeat (2) @(negedge clk);
        check("R7 idle", {63'd0, out_valid}, 64'd0);
        check("R7 hold", out_result, held);

        rst = 1'b1;
        @(negedge clk);
        check("R8 result", out_result, 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule